// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Register Bank

This block controls one general-purpose I/O port of eight pins through three registers and a control register on a small synchronous bus. A direction register picks, per pin, whether the pad driver is enabled (bit 0) or the pin is an input with its driver in high impedance (bit 1). An output latch holds the value driven on every output pin. A pin-level address returns the pad levels seen through a two-flop synchronizer. Writes to that address land in the output latch.

Reads of the latch address return the latched value and not the pad. Software can therefore run read-modify-write sequences on the latch without external loading on the pads corrupting them. A single enable bit in the control register turns on weak pull-ups for the whole port. Each pin's pull-up control is raised only while that pin is configured as an input.

Top module: `gpio_port_top`

## Requirements
- R1: After reset the direction register is all ones, the latch is all zeros and the pull-up enable is clear, so padOe, padOut and padPullUp are all zero.
- R2: padOe[i] is 1 exactly when direction bit i is 0; direction bit 1 means input with the driver off.
- R3: padOut carries the output latch contents on every bit, from the clock edge that follows a latch write.
- R4: A read at address 0 returns padIn as it stood before the second rising edge preceding the read; a pad change is not visible after only one edge.
- R5: A write at address 0 updates the output latch exactly as a write at address 1 does.
- R6: A read at address 1 returns the output latch, whatever the pad levels.
- R7: A read at address 2 returns the direction register as last written.
- R8: Address 3 holds the port pull-up enable in bit 7. Its other bits read as 0, and writing them has no effect.
- R9: padPullUp[i] is 1 exactly when the pull-up enable is set and direction bit i is 1.
- R10: With busWrEn low, no register changes, whatever busAddr and busWrData hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select: 0 pin level, 1 latch, 2 direction, 3 control |
| busWrEn | input | 1 | Single-cycle write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| padIn | input | 8 | Levels sampled from the pads |
| padOut | output | 8 | Value for each pad driver |
| padOe | output | 8 | Pad driver enable, 1 = drive |
| padPullUp | output | 8 | Weak pull-up enable per pad |

## Verification
A write at the pin-level address updates the latch in the same cycle that the same address is being read. The read must still return the synchronized pad levels and never the newly written data. The bench provokes this by setting pad levels that differ from the written value and holding busAddr at 0 across the write edge. It then checks that the read is unchanged, that padOut shows the new latch and that address 1 returns it. A direction write also changes padOe and padPullUp together on one edge, and both are compared against the written mask.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    REG_PIN = 2'd0,
    REG_LAT = 2'd1,
    REG_DIR = 2'd2,
    REG_CFG = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    latWr;
    logic    dirWr;
    logic    cfgWr;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  regSel_e     regAddr,
  input  logic        wrEn,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.latWr = wrEn && (regAddr == REG_PIN || regAddr == REG_LAT);
    strobe.dirWr = wrEn && (regAddr == REG_DIR);
    strobe.cfgWr = wrEn && (regAddr == REG_CFG);
    strobe.rdSel = regAddr;
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PU_BIT      = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullUp
);

  localparam int LastStage = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] latReg;
  logic                 puEn;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] cfgView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '1;
      latReg <= '0;
      puEn   <= 1'b0;
    end else begin
      if (strobe.dirWr) dirReg <= wrData;
      if (strobe.latWr) latReg <= wrData;
      if (strobe.cfgWr) puEn   <= wrData[PU_BIT];
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncStage[s] <= '0;
        end else if (s == 0) begin
          syncStage[s] <= padIn;
        end else begin
          syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    cfgView         = '0;
    cfgView[PU_BIT] = puEn;
    unique case (strobe.rdSel)
      REG_PIN: rdData = syncStage[LastStage];
      REG_LAT: rdData = latReg;
      REG_DIR: rdData = dirReg;
      REG_CFG: rdData = cfgView;
      default: rdData = '0;
    endcase
  end

  assign padOut    = latReg;
  assign padOe     = ~dirReg;
  assign padPullUp = {PIN_COUNT{puEn}} & dirReg;

endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PU_BIT      = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullUp
);

  ctrlStrobe_t strobe;

  gpio_port_ctrl u_ctrl (
    .regAddr (regSel_e'(busAddr)),
    .wrEn    (busWrEn),
    .strobe  (strobe)
  );

  gpio_port_dp #(
    .PIN_COUNT   (PIN_COUNT),
    .SYNC_STAGES (SYNC_STAGES),
    .PU_BIT      (PU_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (busWrData),
    .padIn     (padIn),
    .rdData    (busRdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullUp (padPullUp)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PIN_COUNT = 8,
  parameter int PU_BIT    = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           busAddr,
  input logic                 busWrEn,
  input logic [PIN_COUNT-1:0] busWrData,
  input logic [PIN_COUNT-1:0] busRdData,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] padPullUp
);

  localparam logic [PIN_COUNT-1:0] CfgMask = PIN_COUNT'(1) << PU_BIT;

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd2) |=> (padOe == ~$past(busWrData))); // R2

  AST_LAT_TO_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[1] == 1'b0) |=> (padOut == $past(busWrData))); // R5

  AST_LAT_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd1) |-> (busRdData == padOut)); // R6

  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd2) |-> (busRdData == ~padOe)); // R7

  AST_CFG_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> ((busRdData & ~CfgMask) == '0)); // R8

  AST_PULLUP_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullUp & padOe) == '0)); // R9

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(padOut) && $stable(padOe) && $stable(padPullUp))); // R10

endmodule

bind gpio_port_top gpio_port_chk #(
  .PIN_COUNT (PIN_COUNT),
  .PU_BIT    (PU_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPullUp (padPullUp)
);

// File: tb/gpio_port_top_bench.sv
module gpio_port_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOut;
  logic [7:0] padOe;
  logic [7:0] padPullUp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_top u_gpio_port_top (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullUp (padPullUp)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // Drive at falling edge, commit at rising edge, return at next falling edge.
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R1", "padOe after reset", padOe, 8'h00);
    check("R1", "padOut after reset", padOut, 8'h00);
    check("R1", "padPullUp after reset", padPullUp, 8'h00);
    busRead(2'd2, r); check("R1", "dir read after reset", r, 8'hFF);
    busRead(2'd1, r); check("R1", "lat read after reset", r, 8'h00);
    busRead(2'd3, r); check("R1", "cfg read after reset", r, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] r;
    busWrite(2'd2, 8'h0F);
    check("R2", "padOe for dir 0F", padOe, 8'hF0);
    busRead(2'd2, r); check("R7", "dir readback 0F", r, 8'h0F);
    busWrite(2'd2, 8'hA5);
    check("R2", "padOe for dir A5", padOe, 8'h5A);
    busRead(2'd2, r); check("R7", "dir readback A5", r, 8'hA5);
  endtask

  task automatic t_latch();
    logic [7:0] r;
    busWrite(2'd1, 8'h3C);
    check("R3", "padOut after latch write", padOut, 8'h3C);
    busRead(2'd1, r); check("R6", "latch readback", r, 8'h3C);
    busWrite(2'd0, 8'h96);
    check("R5", "padOut after pin-address write", padOut, 8'h96);
    busRead(2'd1, r); check("R5", "latch via pin-address write", r, 8'h96);
  endtask

  task automatic t_isolation();
    logic [7:0] r;
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    busRead(2'd1, r); check("R6", "latch read ignores pads", r, 8'h96);
    busRead(2'd0, r); check("R4", "pin read shows pads", r, 8'h00);
  endtask

  task automatic t_sync();
    logic [7:0] r;
    padIn = 8'h11;
    repeat (3) @(negedge clk);
    padIn = 8'hE7;
    @(negedge clk);
    busRead(2'd0, r); check("R4", "pin read after one edge", r, 8'h11);
    @(negedge clk);
    busRead(2'd0, r); check("R4", "pin read after two edges", r, 8'hE7);
  endtask

  task automatic t_pullup();
    logic [7:0] r;
    busWrite(2'd2, 8'hC3);
    check("R9", "pull-ups off while disabled", padPullUp, 8'h00);
    busWrite(2'd3, 8'h80);
    check("R9", "pull-ups on input pins", padPullUp, 8'hC3);
    busRead(2'd3, r); check("R8", "cfg read enable", r, 8'h80);
    busWrite(2'd2, 8'h3C);
    check("R9", "pull-ups follow direction", padPullUp, 8'h3C);
    check("R2", "padOe with new direction", padOe, 8'hC3);
    busWrite(2'd3, 8'h7F);
    busRead(2'd3, r); check("R8", "cfg low bits read zero", r, 8'h00);
    check("R8", "pull-ups off after clear", padPullUp, 8'h00);
    busWrite(2'd3, 8'hFF);
    busRead(2'd3, r); check("R8", "cfg only bit 7 kept", r, 8'h80);
  endtask

  task automatic t_no_write();
    logic [7:0] r;
    busWrEn = 1'b0;
    for (int a = 0; a < 4; a++) begin
      busAddr   = 2'(a);
      busWrData = 8'h00;
      @(negedge clk);
    end
    check("R10", "padOut held", padOut, 8'h96);
    check("R10", "padOe held", padOe, 8'hC3);
    check("R10", "padPullUp held", padPullUp, 8'h3C);
    busRead(2'd3, r); check("R10", "cfg held", r, 8'h80);
  endtask

  task automatic t_same_cycle();
    logic [7:0] r;
    padIn = 8'h5A;
    repeat (3) @(negedge clk);
    busRead(2'd0, r); check("R4", "pin read before write", r, 8'h5A);
    busWrite(2'd0, 8'hC3);
    busRead(2'd0, r); check("R4", "pin read after pin-address write", r, 8'h5A);
    check("R5", "padOut after same-cycle write", padOut, 8'hC3);
    busRead(2'd1, r); check("R6", "latch read after same-cycle write", r, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_latch();
    t_isolation();
    t_sync();
    t_pullup();
    t_no_write();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule